// File: doc/BRIEF.md
# Effective Address Resolver for an 8-bit CPU

This unit turns a decoded addressing-mode code into a final 16-bit operand address or control-transfer target for an 8-bit processor with a 64 KiB address space, which is split into 256 pages of 256 bytes. The instruction sequencer pulses `start` with the mode code, the program counter (already pointing at the first operand byte), and the two index registers X and Y. The unit then walks through the operand bytes, and through pointer bytes where the mode needs them, using a byte-wide read port with one cycle of latency. When it finishes, it raises `done` for exactly one cycle. In that cycle `ea` holds the result and `pc_next` holds the program counter advanced past every operand byte.

The unit is built around a six-state controller:

- **IDLE** waits for `start`. In the same cycle as `start` it issues the first operand read.
- **OPND_LO** receives the first operand byte.
- **OPND_HI** receives the second operand byte.
- **PTR_LO** receives the low byte of a pointer.
- **PTR_HI** receives the high byte of a pointer.
- **FINISH** presents the result.

The transitions are:

- IDLE to FINISH for modes that fetch nothing.
- IDLE to OPND_LO for every other mode.
- OPND_LO to FINISH for page-zero and branch modes.
- OPND_LO to OPND_HI for two-byte modes.
- OPND_LO to PTR_LO for the page-zero pointer modes.
- OPND_HI to FINISH for absolute modes.
- OPND_HI to PTR_LO for the jump pointer.
- PTR_LO to PTR_HI, then PTR_HI to FINISH.
- FINISH to IDLE.

A `start` seen in any state other than IDLE is ignored.

Top module: `addr_resolver`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `done` and `mem_rd` are 0.
- R2: Mode codes 0 (implied), 1 (accumulator) and the unused codes 13–15 issue no memory read. `done` rises one cycle after `start`, with `ea` = 0x0000 and `pc_next` = `pc_in`.
- R3: Mode 2 (immediate) issues no read. `done` rises one cycle after `start`, with `ea` = `pc_in` and `pc_next` = `pc_in`+1.
- R4: Modes 3 (page zero), 4 (page zero + X) and 5 (page zero + Y) read one byte at `pc_in`. The result is `ea` = {0x00, byte + index mod 256}, so base 0xFF with index 0x10 gives 0x000F. `pc_next` = `pc_in`+1, and `done` rises two cycles after `start`.
- R5: Modes 6 (absolute), 7 (absolute + X) and 8 (absolute + Y) read the low address byte at `pc_in` and the high byte at `pc_in`+1. The index is added as a full 16-bit sum, carrying into the high byte and wrapping at 0xFFFF. `pc_next` = `pc_in`+2, and `done` rises three cycles after `start`.
- R6: Mode 9 (X-indexed pointer) forms the pointer P = (byte + X) mod 256 on page zero. It reads the low byte at P and the high byte at (P+1) mod 256. `pc_next` = `pc_in`+1, and `done` rises four cycles after `start`.
- R7: Mode 10 (pointer then Y) reads the low byte at the page-zero operand B and the high byte at (B+1) mod 256. It then adds Y as a 16-bit sum. `pc_next` = `pc_in`+1, and `done` rises four cycles after `start`.
- R8: Mode 11 (jump through pointer) takes its pointer from the two operand bytes, low byte first. It reads the target low byte at the pointer and the high byte at pointer+1, with a full 16-bit increment. `pc_next` = `pc_in`+2, and `done` rises five cycles after `start`.
- R9: Mode 12 (relative branch) treats its operand byte as two's complement. The result is `ea` = `pc_in`+1+offset as a 16-bit sum that carries across pages and wraps at the ends of memory. `pc_next` = `pc_in`+1, and `done` rises two cycles after `start`.
- R10: `done` is high for exactly one cycle per accepted `start`. A `start` that arrives while a resolution is in progress, including the `done` cycle itself, changes neither the result nor the number of `done` pulses.
- R11: For modes 3–12, `mem_rd` is 1 with `mem_addr` = `pc_in` in the same cycle as the accepted `start`. `mem_rd` is never high while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a resolution; accepted only in IDLE |
| mode | input | 4 | Addressing-mode code (encoding in R2–R9) |
| pc_in | input | 16 | Address of the first operand byte |
| x_idx | input | 8 | X index register value |
| y_idx | input | 8 | Y index register value |
| mem_rd | output | 1 | Read strobe to the byte memory |
| mem_addr | output | 16 | Read address |
| mem_data | input | 8 | Read data, valid one cycle after `mem_rd` |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Effective address or control-transfer target, valid with `done` |
| pc_next | output | 16 | Program counter past the operand bytes, valid with `done` |

## Verification
Two of the unit's functions can meet in one clock: accepting a new request, and either fetching for or completing the request already in progress. The bench raises `start` with a different mode and program counter in the first busy cycle of a pointer walk, in the middle of a jump-pointer fetch, and in the very cycle `done` is high. A behavioural model predicts the single `done` pulse and its result from the original request alone. Any second pulse, shifted latency or altered address is a miscompare.

// File: rtl/ar_pkg.sv
package ar_pkg;

    localparam int DW   = 8;
    localparam int AW   = 2 * DW;
    localparam int MW   = 4;

    typedef enum logic [MW-1:0] {
        AM_IMP  = 4'd0,
        AM_ACC  = 4'd1,
        AM_IMM  = 4'd2,
        AM_ZP   = 4'd3,
        AM_ZPX  = 4'd4,
        AM_ZPY  = 4'd5,
        AM_ABS  = 4'd6,
        AM_ABSX = 4'd7,
        AM_ABSY = 4'd8,
        AM_INDX = 4'd9,
        AM_INDY = 4'd10,
        AM_IND  = 4'd11,
        AM_REL  = 4'd12
    } am_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPND_LO,
        S_OPND_HI,
        S_PTR_LO,
        S_PTR_HI,
        S_FINISH
    } st_e;

endpackage

// File: rtl/ar_mode_info.sv
module ar_mode_info
    import ar_pkg::*;
(
    input  logic [MW-1:0] mode,
    output logic [1:0]    n_oper,
    output logic          fetches
);

    always_comb begin
        n_oper  = 2'd0;
        fetches = 1'b0;
        case (mode)
            AM_IMM: begin
                n_oper  = 2'd1;
            end
            AM_ZP, AM_ZPX, AM_ZPY, AM_INDX, AM_INDY, AM_REL: begin
                n_oper  = 2'd1;
                fetches = 1'b1;
            end
            AM_ABS, AM_ABSX, AM_ABSY, AM_IND: begin
                n_oper  = 2'd2;
                fetches = 1'b1;
            end
            default: begin
                n_oper  = 2'd0;
                fetches = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ar_step.sv
module ar_step
    import ar_pkg::*;
(
    input  st_e           state,
    input  logic          start,
    input  logic          start_fetches,
    input  logic [MW-1:0] mode_q,
    output st_e           nxt
);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start)
                    nxt = start_fetches ? S_OPND_LO : S_FINISH;
            end
            S_OPND_LO: begin
                case (mode_q)
                    AM_ABS, AM_ABSX, AM_ABSY, AM_IND: nxt = S_OPND_HI;
                    AM_INDX, AM_INDY:                 nxt = S_PTR_LO;
                    default:                          nxt = S_FINISH;
                endcase
            end
            S_OPND_HI: begin
                nxt = (mode_q == AM_IND) ? S_PTR_LO : S_FINISH;
            end
            S_PTR_LO:  nxt = S_PTR_HI;
            S_PTR_HI:  nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
        endcase
    end

endmodule

// File: rtl/ar_calc.sv
module ar_calc
    import ar_pkg::*;
#(
    parameter bit JMP_PTR_PAGE_WRAP = 1'b0
) (
    input  logic [MW-1:0] mode_q,
    input  logic [AW-1:0] pc_q,
    input  logic [DW-1:0] x_q,
    input  logic [DW-1:0] y_q,
    input  logic [DW-1:0] lo_q,
    input  logic [DW-1:0] hi_q,
    input  logic [DW-1:0] plo_q,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] short_ea,
    output logic [AW-1:0] abs_ea,
    output logic [AW-1:0] ptr1_addr,
    output logic [AW-1:0] ptr2_addr,
    output logic [AW-1:0] ind_ea
);

    localparam logic [DW-1:0] PAGE0 = '0;

    logic [DW-1:0] idx;
    logic [DW-1:0] zp_sum;
    logic [AW-1:0] rel_off;
    logic [AW-1:0] ptr_base;
    logic [DW-1:0] zp_base_inc;
    logic [AW-1:0] jmp_ptr_inc;

    always_comb begin
        case (mode_q)
            AM_ZPX, AM_ABSX, AM_INDX: idx = x_q;
            AM_ZPY, AM_ABSY, AM_INDY: idx = y_q;
            default:                  idx = '0;
        endcase
    end

    assign zp_sum  = rd_data + idx;
    assign rel_off = {{DW{rd_data[DW-1]}}, rd_data};

    always_comb begin
        case (mode_q)
            AM_REL:         short_ea = pc_q + AW'(1) + rel_off;
            AM_ZPX, AM_ZPY: short_ea = {PAGE0, zp_sum};
            default:        short_ea = {PAGE0, rd_data};
        endcase
    end

    always_comb begin
        case (mode_q)
            AM_ABSX, AM_ABSY: abs_ea = {rd_data, lo_q} + {PAGE0, idx};
            default:          abs_ea = {rd_data, lo_q};
        endcase
    end

    always_comb begin
        case (mode_q)
            AM_INDX: ptr1_addr = {PAGE0, zp_sum};
            AM_IND:  ptr1_addr = {rd_data, lo_q};
            default: ptr1_addr = {PAGE0, rd_data};
        endcase
    end

    always_comb begin
        case (mode_q)
            AM_INDX: ptr_base = {PAGE0, lo_q + x_q};
            AM_IND:  ptr_base = {hi_q, lo_q};
            default: ptr_base = {PAGE0, lo_q};
        endcase
    end

    assign zp_base_inc = ptr_base[DW-1:0] + DW'(1);

    generate
        if (JMP_PTR_PAGE_WRAP) begin : g_jmp_wrap
            assign jmp_ptr_inc = {ptr_base[AW-1:DW], zp_base_inc};
        end else begin : g_jmp_carry
            assign jmp_ptr_inc = ptr_base + AW'(1);
        end
    endgenerate

    assign ptr2_addr = (mode_q == AM_IND) ? jmp_ptr_inc : {PAGE0, zp_base_inc};

    assign ind_ea = {rd_data, plo_q} + ((mode_q == AM_INDY) ? {PAGE0, y_q} : AW'(0));

endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
    import ar_pkg::*;
#(
    parameter bit JMP_PTR_PAGE_WRAP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] mode,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] x_idx,
    input  logic [DW-1:0] y_idx,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_data,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] pc_next
);

    st_e           state;
    st_e           nxt;
    logic [MW-1:0] mode_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] x_q, y_q, lo_q, hi_q, plo_q;
    logic [AW-1:0] ea_q;

    logic [1:0]    in_n_oper, q_n_oper;
    logic          in_fetches, q_fetches;
    logic [AW-1:0] short_ea, abs_ea, ptr1_addr, ptr2_addr, ind_ea;

    ar_mode_info u_info_in (
        .mode    (mode),
        .n_oper  (in_n_oper),
        .fetches (in_fetches)
    );

    ar_mode_info u_info_q (
        .mode    (mode_q),
        .n_oper  (q_n_oper),
        .fetches (q_fetches)
    );

    ar_step u_step (
        .state         (state),
        .start         (start),
        .start_fetches (in_fetches),
        .mode_q        (mode_q),
        .nxt           (nxt)
    );

    ar_calc #(
        .JMP_PTR_PAGE_WRAP (JMP_PTR_PAGE_WRAP)
    ) u_calc (
        .mode_q    (mode_q),
        .pc_q      (pc_q),
        .x_q       (x_q),
        .y_q       (y_q),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .plo_q     (plo_q),
        .rd_data   (mem_data),
        .short_ea  (short_ea),
        .abs_ea    (abs_ea),
        .ptr1_addr (ptr1_addr),
        .ptr2_addr (ptr2_addr),
        .ind_ea    (ind_ea)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // captured request and fetched bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            pc_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            plo_q  <= '0;
            ea_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        pc_q   <= pc_in;
                        x_q    <= x_idx;
                        y_q    <= y_idx;
                        ea_q   <= (mode == AM_IMM) ? pc_in : '0;
                    end
                end
                S_OPND_LO: begin
                    lo_q <= mem_data;
                    ea_q <= short_ea;
                end
                S_OPND_HI: begin
                    hi_q <= mem_data;
                    ea_q <= abs_ea;
                end
                S_PTR_LO: begin
                    plo_q <= mem_data;
                end
                S_PTR_HI: begin
                    ea_q <= ind_ea;
                end
                S_FINISH: begin
                    ea_q <= ea_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        done     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start && in_fetches) begin
                    mem_rd   = 1'b1;
                    mem_addr = pc_in;
                end
            end
            S_OPND_LO: begin
                case (mode_q)
                    AM_ABS, AM_ABSX, AM_ABSY, AM_IND: begin
                        mem_rd   = 1'b1;
                        mem_addr = pc_q + AW'(1);
                    end
                    AM_INDX, AM_INDY: begin
                        mem_rd   = 1'b1;
                        mem_addr = ptr1_addr;
                    end
                    default: ;
                endcase
            end
            S_OPND_HI: begin
                if (mode_q == AM_IND) begin
                    mem_rd   = 1'b1;
                    mem_addr = ptr1_addr;
                end
            end
            S_PTR_LO: begin
                mem_rd   = 1'b1;
                mem_addr = ptr2_addr;
            end
            S_PTR_HI: ;
            S_FINISH: done = 1'b1;
        endcase
    end

    assign ea      = ea_q;
    assign pc_next = pc_q + AW'(q_n_oper);

    logic unused_ok;
    assign unused_ok = &{1'b0, in_n_oper, q_fetches};

endmodule

// File: rtl/ar_chk.sv
module ar_chk
    import ar_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [MW-1:0] mode,
    input logic [AW-1:0] pc_in,
    input st_e           state,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic [AW-1:0] ea,
    input logic [AW-1:0] pc_next
);

    logic          accept;
    logic [MW-1:0] last_mode;

    assign accept = (state == S_IDLE) && start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_mode <= '0;
        else if (accept)
            last_mode <= mode;
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_rd));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    no_fetch_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !done);

    // R11
    first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode >= 4'd3 && mode <= 4'd12) |-> (mem_rd && mem_addr == pc_in));

    // R2
    no_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (mode <= 4'd1 || mode >= 4'd13)) |-> !mem_rd ##1 (done && ea == '0));

    // R3
    imm_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == 4'd2) |=>
            (done && ea == $past(pc_in) && pc_next == 16'($past(pc_in) + 16'd1)));

    // R4
    page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last_mode >= 4'd3 && last_mode <= 4'd5) |-> (ea[AW-1:DW] == '0));

endmodule

bind addr_resolver ar_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .pc_in    (pc_in),
    .state    (state),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .done     (done),
    .ea       (ea),
    .pc_next  (pc_next)
);

// File: tb/addr_resolver_tb.sv
module addr_resolver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_idx = '0;
    logic [7:0]  y_idx = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data = '0;
    logic        done;
    logic [15:0] ea;
    logic [15:0] pc_next;

    int vectors = 0;
    int fails   = 0;
    logic [7:0] mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_resolver u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .pc_in    (pc_in),
        .x_idx    (x_idx),
        .y_idx    (y_idx),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .done     (done),
        .ea       (ea),
        .pc_next  (pc_next)
    );

    function automatic logic [7:0] rdm(input int a);
        int m = a & 16'hFFFF;
        if (mem.exists(m)) return mem[m];
        return 8'(m ^ (m >> 8) ^ 8'h5A);
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_data <= rdm(int'(mem_addr));
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run(input int md, input int pc, input int x, input int y,
                       input int poke, input string req);
        int lat, e_ea, e_pc, p, off;
        bit fetch;
        fetch = 1'b1;
        case (md)
            2: begin lat = 1; e_ea = pc; e_pc = pc + 1; fetch = 1'b0; end
            3: begin lat = 2; e_ea = rdm(pc); e_pc = pc + 1; end
            4: begin lat = 2; e_ea = (rdm(pc) + x) % 256; e_pc = pc + 1; end
            5: begin lat = 2; e_ea = (rdm(pc) + y) % 256; e_pc = pc + 1; end
            6, 7, 8: begin
                lat = 3;
                e_ea = rdm(pc) + 256 * rdm(pc + 1);
                if (md == 7) e_ea += x;
                if (md == 8) e_ea += y;
                e_pc = pc + 2;
            end
            9: begin
                lat = 4; p = (rdm(pc) + x) % 256;
                e_ea = rdm(p) + 256 * rdm((p + 1) % 256); e_pc = pc + 1;
            end
            10: begin
                lat = 4; p = rdm(pc);
                e_ea = rdm(p) + 256 * rdm((p + 1) % 256) + y; e_pc = pc + 1;
            end
            11: begin
                lat = 5; p = rdm(pc) + 256 * rdm(pc + 1);
                e_ea = rdm(p) + 256 * rdm(p + 1); e_pc = pc + 2;
            end
            12: begin
                lat = 2; off = rdm(pc);
                if (off > 127) off -= 256;
                e_ea = pc + 1 + off; e_pc = pc + 1;
            end
            default: begin lat = 1; e_ea = 0; e_pc = pc; fetch = 1'b0; end
        endcase
        e_ea &= 16'hFFFF;
        e_pc &= 16'hFFFF;

        @(negedge clk);
        start = 1'b1; mode = 4'(md); pc_in = 16'(pc); x_idx = 8'(x); y_idx = 8'(y);
        #1;
        // R11: first fetch issued with the request, none for operand-free modes (R2, R3)
        chk(mem_rd == fetch, "R11 fetch strobe", int'(mem_rd), int'(fetch));
        if (fetch) chk(mem_addr == 16'(pc), "R11 fetch address", int'(mem_addr), pc);
        for (int k = 1; k <= lat + 2; k++) begin
            @(negedge clk);
            start = 1'b0;
            // R10: exactly one done pulse, at the mode's latency
            chk(done == (k == lat), {req, " done timing / R10"}, int'(done), int'(k == lat));
            if (k == lat) begin
                chk(ea == 16'(e_ea), {req, " ea"}, int'(ea), e_ea);
                chk(pc_next == 16'(e_pc), {req, " pc_next"}, int'(pc_next), e_pc);
            end
            if (k == poke) begin
                start = 1'b1; mode = 4'd2; pc_in = 16'hBEEF;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done, "R1 done in reset", int'(done), 0);
        chk(!mem_rd, "R1 mem_rd in reset", int'(mem_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done, "R1 done after reset", int'(done), 0);

        // R2 implied, accumulator, unused code
        run(0, 16'h0300, 0, 0, 0, "R2 implied");
        run(1, 16'h0301, 0, 0, 0, "R2 accumulator");
        run(14, 16'h0302, 0, 0, 0, "R2 unused code");
        // R3 immediate
        run(2, 16'h0400, 0, 0, 0, "R3 immediate");
        // R4 page zero
        mem.delete(); mem[16'h0500] = 8'h44;
        run(3, 16'h0500, 0, 0, 0, "R4 zp");
        mem.delete(); mem[16'h0510] = 8'hFF;
        run(4, 16'h0510, 8'h10, 0, 0, "R4 zpx wrap");
        mem.delete(); mem[16'h0520] = 8'h80;
        run(5, 16'h0520, 0, 8'h90, 0, "R4 zpy wrap");
        // R5 absolute
        mem.delete(); mem[16'h0600] = 8'h34; mem[16'h0601] = 8'h12;
        run(6, 16'h0600, 0, 0, 0, "R5 abs");
        mem.delete(); mem[16'h0610] = 8'hF0; mem[16'h0611] = 8'h12;
        run(7, 16'h0610, 8'h20, 0, 0, "R5 absx carry");
        mem.delete(); mem[16'h0620] = 8'hF0; mem[16'h0621] = 8'hFF;
        run(8, 16'h0620, 0, 8'h20, 0, "R5 absy wrap");
        // R6 indexed pointer on page zero
        mem.delete(); mem[16'h0700] = 8'hF0; mem[16'h00FF] = 8'h78; mem[16'h0000] = 8'h56;
        run(9, 16'h0700, 8'h0F, 0, 0, "R6 indx wrap");
        // R7 pointer then Y
        mem.delete(); mem[16'h0710] = 8'hFF; mem[16'h00FF] = 8'hF0; mem[16'h0000] = 8'h20;
        run(10, 16'h0710, 0, 8'h30, 0, "R7 indy wrap carry");
        // R8 jump pointer crossing a page
        mem.delete(); mem[16'h0800] = 8'hFF; mem[16'h0801] = 8'h12;
        mem[16'h12FF] = 8'hCD; mem[16'h1300] = 8'hAB;
        run(11, 16'h0800, 0, 0, 0, "R8 jump ptr");
        // R9 relative
        mem.delete(); mem[16'h10FE] = 8'h05;
        run(12, 16'h10FE, 0, 0, 0, "R9 rel forward page");
        mem.delete(); mem[16'h0040] = 8'h80;
        run(12, 16'h0040, 0, 0, 0, "R9 rel backward wrap");
        // R10 start collisions
        mem.delete(); mem[16'h0800] = 8'hFF; mem[16'h0801] = 8'h12;
        mem[16'h12FF] = 8'hCD; mem[16'h1300] = 8'hAB;
        run(11, 16'h0800, 0, 0, 2, "R10 start mid jump ptr");
        mem.delete(); mem[16'h0500] = 8'h44;
        run(3, 16'h0500, 0, 0, 2, "R10 start in done cycle");
        mem.delete(); mem[16'h0710] = 8'h40; mem[16'h0040] = 8'h11; mem[16'h0041] = 8'h22;
        run(10, 16'h0710, 0, 8'h01, 1, "R10 start first busy cycle");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule